// File: doc/BRIEF.md
# Multi-Mode PWM/PDM Generator

This block converts a signed, fixed-point duty command into switching signals on two outputs plus an active-low enable output for a motor power stage. A two-bit mode input selects one of four output formats:

- PWM of the magnitude with a direction line.
- Up/down PWM, where the pulses go to one output or the other according to sign.
- First-order pulse-density modulation with a direction line.
- Direction with PWM on the second output, for locked-antiphase bridges.

Two rate inputs drive independent phase accumulators. One accumulator advances the PWM period counter. The other paces the PDM slots, so the PDM slot rate can be set apart from the PWM carrier and can run as fast as the clock.

The PWM path takes the duty magnitude and the sign into a holding register only when a new period begins. As a result, a pulse is never cut short and the direction line never changes inside a period. The PDM path adds the magnitude into an accumulator on every slot tick. The carry becomes the output, and it is held for the full slot.

Top module: `pwm_pdm_gen`

## Requirements
- R1: With mode_i = 0, out0_o carries PWM whose high time per period equals the saturated magnitude, and out1_o is the direction (1 when the latched command is negative, 0 otherwise).
- R2: With mode_i = 1, the PWM appears on out0_o for a positive command and on out1_o for a negative one; the other output stays low, and both are never high in the same cycle.
- R3: With mode_i = 2, out0_o is the carry of a first-order accumulator that adds the magnitude once per slot tick and holds each pulse or space for a whole slot; over FS slots exactly the magnitude count of pulses appears; out1_o is the direction, updated per slot.
- R4: With mode_i = 3, out0_o is the direction and out1_o carries the PWM.
- R5: en_n_o equals the inverse of enable_i one clock later; while en_n_o is high, out0_o and out1_o are both low.
- R6: duty_i is two's complement; the magnitude is min(|duty_i|, FS) with FS = 2^MAG_W (512 by default), so full scale is reached inclusively at ±512 and larger values saturate.
- R7: A PWM period is FS ticks; pwm_rate_i adds pwm_rate_i+1 to a RATE_W-bit accumulator each clock and each carry is a tick, so all-ones gives a tick every clock and 16'h7FFF gives one every two clocks.
- R8: pdm_rate_i sets the PDM slot tick the same way, independently of pwm_rate_i; at magnitude FS/2 the PDM output alternates pulse and space every slot.
- R9: Magnitude and direction for PWM are taken only when the period counter wraps to zero, so every PWM pulse has the full width of one command and direction changes only at the start of a period.
- R10: During and after reset, until enabled, out0_o and out1_o are low and en_n_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Output enable request |
| mode_i | input | 2 | Output format: 0 PWM/dir, 1 up/down, 2 PDM/dir, 3 dir/PWM |
| duty_i | input | DUTY_W (11) | Signed duty command, full scale ±2^MAG_W |
| pwm_rate_i | input | RATE_W (16) | PWM tick rate increment minus one |
| pdm_rate_i | input | RATE_W (16) | PDM slot rate increment minus one |
| out0_o | output | 1 | Switching output 0 |
| out1_o | output | 1 | Switching output 1 |
| en_n_o | output | 1 | Active-low enable to the power stage |

## Verification
en_n_o is due exactly one clock after enable_i changes, and the bench samples it at the first falling edge after that rising edge. A new duty or direction takes effect only at the next PWM wrap, so it can appear up to two periods after it is applied. Each duty check therefore waits more than two periods. It then counts high samples over one whole period, or over a whole multiple of the slot pattern length. That count does not depend on the phase of the window. The boundary checks instead look at the length of every complete pulse, and at whether the direction edges line up with rising PWM edges. The change is applied at an unaligned cycle on purpose.

// File: rtl/pwm_pdm_pkg.sv
package pwm_pdm_pkg;
  typedef enum logic [1:0] {
    MODE_PWM_DIR = 2'd0,
    MODE_UP_DOWN = 2'd1,
    MODE_PDM_DIR = 2'd2,
    MODE_DIR_PWM = 2'd3
  } mode_e;
endpackage

// File: rtl/pwm_rate_tick.sv
module pwm_rate_tick #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W:0]   sum;

  // increment is rate+1, so all-ones ticks every clock
  assign sum    = {1'b0, acc_q} + {1'b0, rate_i} + (RATE_W+1)'(1);
  assign tick_o = sum[RATE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[RATE_W-1:0];
  end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int MAG_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [MAG_W:0]   mag_i,
  input  logic             dir_i,
  output logic             bit_o,
  output logic             dir_o,
  output logic [MAG_W:0]   mag_o,
  output logic [MAG_W-1:0] cnt_o
);
  logic [MAG_W-1:0] cnt_q;
  logic [MAG_W:0]   mag_q;
  logic             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mag_q <= '0;
      dir_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      // take the new command as the counter wraps to zero
      if (cnt_q == '1) begin
        mag_q <= mag_i;
        dir_q <= dir_i;
      end
    end
  end

  assign bit_o = ({1'b0, cnt_q} < mag_q);
  assign dir_o = dir_q;
  assign mag_o = mag_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pdm_slot_core.sv
module pdm_slot_core #(
  parameter int MAG_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [MAG_W:0] mag_i,
  input  logic           dir_i,
  output logic           bit_o,
  output logic           dir_o
);
  logic [MAG_W-1:0] acc_q;
  logic [MAG_W:0]   sum;
  logic             bit_q;
  logic             dir_q;

  // mag <= FS and acc < FS, so the sum fits and its MSB is the carry
  assign sum = {1'b0, acc_q} + mag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      bit_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (tick_i) begin
      acc_q <= sum[MAG_W-1:0];
      bit_q <= sum[MAG_W];
      dir_q <= dir_i;
    end
  end

  assign bit_o = bit_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/pwm_pdm_gen.sv
module pwm_pdm_gen
  import pwm_pdm_pkg::*;
#(
  parameter int DUTY_W = 11,
  parameter int MAG_W  = 9,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [1:0]        mode_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [RATE_W-1:0] pwm_rate_i,
  input  logic [RATE_W-1:0] pdm_rate_i,
  output logic              out0_o,
  output logic              out1_o,
  output logic              en_n_o
);
  localparam int unsigned FS = 2**MAG_W;

  logic [DUTY_W-1:0] abs_v;
  logic [MAG_W:0]    mag_sat;
  logic              cmd_neg;
  logic              pwm_tick, pdm_tick;
  logic              pwm_bit, pwm_dir, pdm_bit, pdm_dir;
  logic [MAG_W:0]    pwm_mag;
  logic [MAG_W-1:0]  pwm_cnt;
  logic              o0_d, o1_d;
  mode_e             mode;

  assign cmd_neg = duty_i[DUTY_W-1];
  // most negative code gives 2^(DUTY_W-1) as an unsigned pattern, still > FS
  assign abs_v   = cmd_neg ? (~duty_i + 1'b1) : duty_i;
  assign mag_sat = (abs_v > DUTY_W'(FS)) ? (MAG_W+1)'(FS) : abs_v[MAG_W:0];

  pwm_rate_tick #(.RATE_W(RATE_W)) u_pwm_rate (
    .clk_i (clk_i), .rst_ni(rst_ni), .rate_i(pwm_rate_i), .tick_o(pwm_tick)
  );

  pwm_rate_tick #(.RATE_W(RATE_W)) u_pdm_rate (
    .clk_i (clk_i), .rst_ni(rst_ni), .rate_i(pdm_rate_i), .tick_o(pdm_tick)
  );

  pwm_period_core #(.MAG_W(MAG_W)) u_pwm (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(pwm_tick),
    .mag_i (mag_sat), .dir_i(cmd_neg),
    .bit_o (pwm_bit), .dir_o(pwm_dir), .mag_o(pwm_mag), .cnt_o(pwm_cnt)
  );

  pdm_slot_core #(.MAG_W(MAG_W)) u_pdm (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(pdm_tick),
    .mag_i (mag_sat), .dir_i(cmd_neg),
    .bit_o (pdm_bit), .dir_o(pdm_dir)
  );

  assign mode = mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_PWM_DIR: begin o0_d = pwm_bit;            o1_d = pwm_dir;           end
      MODE_UP_DOWN: begin o0_d = pwm_bit & ~pwm_dir; o1_d = pwm_bit & pwm_dir; end
      MODE_PDM_DIR: begin o0_d = pdm_bit;            o1_d = pdm_dir;           end
      default:      begin o0_d = pwm_dir;            o1_d = pwm_bit;           end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out0_o <= 1'b0;
      out1_o <= 1'b0;
      en_n_o <= 1'b1;
    end else begin
      out0_o <= enable_i & o0_d;
      out1_o <= enable_i & o1_d;
      en_n_o <= ~enable_i;
    end
  end
endmodule

// File: rtl/pwm_pdm_gen_chk.sv
module pwm_pdm_gen_chk #(
  parameter int MAG_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [1:0]       mode_i,
  input logic             out0_o,
  input logic             out1_o,
  input logic             en_n_o,
  input logic             pwm_dir,
  input logic [MAG_W:0]   pwm_mag,
  input logic [MAG_W-1:0] pwm_cnt
);
  localparam int unsigned FS = 2**MAG_W;

  AST_EN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (en_n_o != $past(enable_i))); // R5

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_n_o |-> (!out0_o && !out1_o)); // R5

  AST_UPDOWN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |=> !(out0_o && out1_o)); // R2

  AST_DIR_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwm_dir) |-> (pwm_cnt == '0)); // R9

  AST_MAG_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwm_mag) |-> (pwm_cnt == '0)); // R9

  AST_MAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_mag <= (MAG_W+1)'(FS)); // R6
endmodule

bind pwm_pdm_gen pwm_pdm_gen_chk #(.MAG_W(MAG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .enable_i(enable_i),
  .mode_i  (mode_i),
  .out0_o  (out0_o),
  .out1_o  (out1_o),
  .en_n_o  (en_n_o),
  .pwm_dir (pwm_dir),
  .pwm_mag (pwm_mag),
  .pwm_cnt (pwm_cnt)
);

// File: tb/sim_pwm_pdm_gen.sv
module sim_pwm_pdm_gen;
  localparam int DUTY_W = 11;
  localparam int MAG_W  = 9;
  localparam int RATE_W = 16;
  localparam int FS     = 512;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              enable_i = 1'b0;
  logic [1:0]        mode_i = 2'd0;
  logic [DUTY_W-1:0] duty_i = '0;
  logic [RATE_W-1:0] pwm_rate_i = '1;
  logic [RATE_W-1:0] pdm_rate_i = '1;
  logic              out0_o, out1_o, en_n_o;

  int nchecks = 0;
  int nerrs   = 0;

  always #5 clk_i = ~clk_i;

  pwm_pdm_gen #(.DUTY_W(DUTY_W), .MAG_W(MAG_W), .RATE_W(RATE_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .mode_i(mode_i),
    .duty_i(duty_i), .pwm_rate_i(pwm_rate_i), .pdm_rate_i(pdm_rate_i),
    .out0_o(out0_o), .out1_o(out1_o), .en_n_o(en_n_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic count_hi(input int n, output int c0, output int c1, output int cn);
    c0 = 0; c1 = 0; cn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      c0 += int'(out0_o); c1 += int'(out1_o); cn += int'(en_n_o);
    end
  endtask

  task automatic apply(input logic [1:0] m, input int d, input int settle);
    mode_i = m;
    duty_i = DUTY_W'(d);
    wait_cyc(settle);
  endtask

  task automatic t_reset;
    int c0, c1, cn;
    count_hi(8, c0, c1, cn);
    chk("R10 out0 low in reset", c0, 0);
    chk("R10 out1 low in reset", c1, 0);
    chk("R10 en_n high in reset", cn, 8);
    rst_ni = 1'b1;
    duty_i = DUTY_W'(300);
    count_hi(1200, c0, c1, cn);
    chk("R10 out0 low after reset, disabled", c0, 0);
    chk("R5 en_n high while disabled", cn, 1200);
  endtask

  task automatic t_enable;
    int c0, c1, cn;
    enable_i = 1'b1;
    @(negedge clk_i);
    chk("R5 en_n low one clock after enable", int'(en_n_o), 0);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R5 en_n high one clock after disable", int'(en_n_o), 1);
    count_hi(FS, c0, c1, cn);
    chk("R5 no pulses while disabled", c0 + c1, 0);
    enable_i = 1'b1;
  endtask

  task automatic t_mode0;
    int c0, c1, cn;
    apply(2'd0, 100, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R1 pwm high count +100", c0, 100);
    chk("R1 dir low for positive", c1, 0);
    apply(2'd0, -200, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R1 pwm high count -200", c0, 200);
    chk("R1 dir high for negative", c1, FS);
  endtask

  task automatic t_mode1;
    int c0, c1, cn;
    apply(2'd1, 150, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R2 up output +150", c0, 150);
    chk("R2 down output idle +150", c1, 0);
    apply(2'd1, -150, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R2 up output idle -150", c0, 0);
    chk("R2 down output -150", c1, 150);
  endtask

  task automatic t_pdm;
    int c0, c1, cn, flips;
    logic prev;
    apply(2'd2, 256, 600);
    count_hi(FS, c0, c1, cn);
    chk("R3 pdm pulses at 256", c0, 256);
    chk("R3 pdm dir low", c1, 0);
    flips = 0;
    @(negedge clk_i);
    prev = out0_o;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      if (out0_o != prev) flips++;
      prev = out0_o;
    end
    chk("R8 pdm half duty alternates each slot", flips, 64);
    apply(2'd2, -64, 600);
    count_hi(FS, c0, c1, cn);
    chk("R3 pdm pulses at -64", c0, 64);
    chk("R3 pdm dir high", c1, FS);
  endtask

  task automatic t_mode3;
    int c0, c1, cn;
    apply(2'd3, 300, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R4 dir on out0 positive", c0, 0);
    chk("R4 pwm on out1 +300", c1, 300);
    apply(2'd3, -300, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R4 dir on out0 negative", c0, FS);
    chk("R4 pwm on out1 -300", c1, 300);
  endtask

  task automatic t_sat;
    int c0, c1, cn;
    apply(2'd0, 512, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R6 full scale +512", c0, FS);
    apply(2'd0, 800, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R6 saturate +800", c0, FS);
    apply(2'd0, -1024, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R6 saturate -1024", c0, FS);
    chk("R6 dir for -1024", c1, FS);
    apply(2'd0, 0, 1100);
    count_hi(FS, c0, c1, cn);
    chk("R6 zero duty", c0 + c1, 0);
  endtask

  task automatic t_rate;
    int c0, c1, cn;
    pwm_rate_i = 16'h7FFF;
    apply(2'd0, 100, 2200);
    count_hi(2 * FS, c0, c1, cn);
    chk("R7 half tick rate doubles pulse", c0, 200);
    pwm_rate_i = '1;
    pdm_rate_i = 16'h3FFF;
    apply(2'd2, 256, 2200);
    count_hi(4 * FS, c0, c1, cn);
    chk("R8 pdm quarter slot rate", c0, 4 * 256);
    pdm_rate_i = '1;
  endtask

  task automatic t_boundary;
    int run, n100, n400, nbad;
    logic prev, started;
    apply(2'd0, 100, 1100);
    run = 0; n100 = 0; n400 = 0; nbad = 0; started = 1'b0;
    @(negedge clk_i);
    prev = out0_o;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (out0_o && !prev) begin started = 1'b1; run = 0; end
      if (out0_o) run++;
      if (!out0_o && prev && started) begin
        if (run == 100) n100++;
        else if (run == 400) n400++;
        else begin
          nbad++;
          $display("FAIL R9 truncated pulse actual %0d expected 100 or 400", run);
        end
      end
      prev = out0_o;
      if (i == 700) duty_i = DUTY_W'(400);
    end
    chk("R9 no truncated pulse", nbad, 0);
    chk("R9 old width seen", int'(n100 > 0), 1);
    chk("R9 new width seen", int'(n400 > 0), 1);
  endtask

  task automatic t_dir;
    int changes, bad;
    logic p0, p1;
    apply(2'd0, 100, 1100);
    changes = 0; bad = 0;
    @(negedge clk_i);
    p0 = out0_o; p1 = out1_o;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk_i);
      if (out1_o != p1) begin
        changes++;
        if (!(out0_o && !p0)) bad++;
      end
      p0 = out0_o; p1 = out1_o;
      if (i == 301) duty_i = DUTY_W'(-100);
    end
    chk("R9 direction changed once", changes, 1);
    chk("R9 direction change at period start", bad, 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    nchecks++;
    nerrs++;
    $display("FAIL watchdog actual expired expected done");
    summary();
  end

  initial begin
    t_reset();
    t_enable();
    t_mode0();
    t_mode1();
    t_pdm();
    t_mode3();
    t_sat();
    t_rate();
    t_boundary();
    t_dir();
    summary();
  end
endmodule